// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns the housekeeping side of a 512-row asynchronous DRAM. After reset it counts out a start-up delay, then drives a fixed number of initialization refresh cycles on the strobes. Only after those cycles does it raise `ready` and let the access sequencer use the memory. From then on an interval timer adds one pending refresh per row period. With the default parameters the period is an 8 ms window spread over 512 rows. A low-power option widens the window to 64 ms.

Pending refreshes are requested from the access sequencer through a request/grant pair. The block takes the bus only when the grant is high and the sequencer reports that no row is open. It then runs every pending refresh back to back and hands the bus back once the precharge of the last one has finished. Each refresh runs in one of two forms, chosen at its start by `ras_only_mode`:
- CAS-before-RAS: the DRAM steps its own row counter and no address is driven.
- RAS-only: CAS stays high and a 9-bit row counter inside the block is placed on the address bus.

All strobe widths are derived from nanosecond limits and the clock frequency parameter, rounded up to whole cycles. At the default 100 MHz they come out as follows:

| Interval | Cycles |
|---|---|
| Lead phase, before RAS falls | 1 |
| RAS low | 6 |
| Precharge | 5 |
| Total per refresh | 12 |

Top module: `rfsh_sched`

## Requirements
- R1: After reset is released, RAS and CAS stay high and `ready` stays low for STARTUP_US × CLK_MHZ cycles (the start-up wait).
- R2: After the wait, exactly INIT_CYCLES (8) refresh cycles are run without any grant, and `ready` rises when the precharge of the last of them ends, T_PRE (5) cycles after its RAS rise.
- R3: In CAS-before-RAS mode (`ras_only_mode`=0), CAS goes low one cycle before RAS falls and stays low until RAS rises; `addr_oe` stays 0.
- R4: In RAS-only mode (`ras_only_mode`=1), CAS stays high for the whole refresh, and `addr_oe` is 1 from the cycle before RAS falls until RAS rises, with `row_addr` stable while RAS is low.
- R5: Every refresh holds RAS low for exactly 6 cycles, and RAS is high for at least 6 cycles before each fall, so that one refresh spans at least 12 cycles (120 ns).
- R6: `row_addr` starts at 0, advances by one on each completed refresh of either mode, and wraps from 511 to 0.
- R7: Once `ready` is high, one pending refresh is added every REFRESH_WINDOW_US × CLK_MHZ / 512 cycles, and `rfsh_req` is high exactly while the block is idle and `pend_cnt` is non-zero.
- R8: `pend_cnt` saturates at 8; an interval that would take it past 8 sets `overflow`, which stays set until reset.
- R9: A grant while `row_closed` is 0 is ignored: no strobe moves and `bus_own` stays low.
- R10: When the grant arrives with `row_closed`=1, the block sets `bus_own`, runs every pending refresh back to back, and clears `bus_own` T_PRE (5) cycles after the last RAS rise, leaving `pend_cnt` at 0.
- R11: During reset: `ras_n`=1, `cas_n`=1, `addr_oe`=0, `ready`=0, `rfsh_req`=0, `bus_own`=0, `pend_cnt`=0, `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rst | input | 1 | Synchronous active-high reset |
| ras_only_mode | input | 1 | 1 selects RAS-only refresh, 0 selects CAS-before-RAS; sampled at each refresh start |
| rfsh_gnt | input | 1 | Grant from the access sequencer |
| row_closed | input | 1 | Sequencer reports that no DRAM row is open |
| rfsh_req | output | 1 | Refresh request to the sequencer |
| bus_own | output | 1 | Block is driving the DRAM strobes after a grant |
| ready | output | 1 | Power-up sequence complete |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | Drive `row_addr` onto the DRAM address bus |
| row_addr | output | ROW_BITS (9) | Row for RAS-only refresh |
| pend_cnt | output | clog2(PEND_DEPTH+1) (4) | Refreshes owed |
| overflow | output | 1 | Sticky: a refresh was lost to saturation |

## Verification
The bound checker watches the following on every cycle:
- the RAS low width;
- CAS leading RAS in CAS-before-RAS cycles, and CAS held high while the address is driven;
- the address holding steady under RAS, and the row counter stepping only by one;
- the pending limit and the stickiness of the overflow flag;
- requests appearing only after `ready`;
- bus ownership beginning only on a grant with the row closed.

Only the bench's scenarios can show the behaviours that depend on longer stretches of time:
- the length of the start-up wait and the exact count of initialization cycles;
- the interval rate and the resulting accumulation to saturation;
- a burst that drains exactly the owed refreshes and releases after precharge;
- the row counter wrapping over more than 512 refreshes.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    CTL_WAIT,
    CTL_INIT,
    CTL_READY,
    CTL_OWN
  } ctl_state_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SETUP,
    SEQ_ACT,
    SEQ_PRE
  } seq_state_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int STARTUP_CYC = 20000,
  parameter int REFI_CYC    = 1562
) (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  output logic startup_done,
  output logic tick
);

  localparam int SW = $clog2(STARTUP_CYC + 1);
  localparam int IW = $clog2(REFI_CYC);

  logic [SW-1:0] s_cnt;
  logic [IW-1:0] i_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_cnt        <= '0;
      startup_done <= 1'b0;
    end else if (!startup_done) begin
      if (s_cnt == SW'(STARTUP_CYC - 1)) startup_done <= 1'b1;
      else                               s_cnt <= s_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      i_cnt <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (i_cnt == IW'(REFI_CYC - 1));
      i_cnt <= (i_cnt == IW'(REFI_CYC - 1)) ? '0 : i_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          ovf
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (inc && !dec) begin
      if (cnt == CW'(DEPTH)) ovf <= 1'b1;
      else                   cnt <= cnt + 1'b1;
    end else if (dec && !inc) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/rfsh_strobe.sv
module rfsh_strobe
  import rfsh_pkg::*;
#(
  parameter int T_SETUP = 1,
  parameter int T_ACT   = 6,
  parameter int T_PRE   = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ras_only,
  output logic ras_n,
  output logic cas_n,
  output logic addr_oe,
  output logic done,
  output logic idle
);

  localparam int TMAX = (T_SETUP > T_ACT) ? ((T_SETUP > T_PRE) ? T_SETUP : T_PRE)
                                          : ((T_ACT > T_PRE) ? T_ACT : T_PRE);
  localparam int CW = $clog2(TMAX + 1);

  seq_state_e st, nxt;
  logic [CW-1:0] cnt, nxt_cnt;
  logic mode_q, nxt_mode, launch, busy_nxt;

  always_comb begin
    nxt     = st;
    nxt_cnt = cnt;
    launch  = 1'b0;
    unique case (st)
      SEQ_IDLE: if (start) launch = 1'b1;
      SEQ_SETUP:
        if (cnt == '0) begin
          nxt     = SEQ_ACT;
          nxt_cnt = CW'(T_ACT - 1);
        end else nxt_cnt = cnt - 1'b1;
      SEQ_ACT:
        if (cnt == '0) begin
          nxt     = SEQ_PRE;
          nxt_cnt = CW'(T_PRE - 1);
        end else nxt_cnt = cnt - 1'b1;
      SEQ_PRE:
        if (cnt == '0) begin
          if (start) launch = 1'b1;
          else       nxt    = SEQ_IDLE;
        end else nxt_cnt = cnt - 1'b1;
      default: nxt = SEQ_IDLE;
    endcase
    if (launch) begin
      nxt     = SEQ_SETUP;
      nxt_cnt = CW'(T_SETUP - 1);
    end
    nxt_mode = launch ? ras_only : mode_q;
    busy_nxt = (nxt == SEQ_SETUP) || (nxt == SEQ_ACT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SEQ_IDLE;
      cnt     <= '0;
      mode_q  <= 1'b0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      addr_oe <= 1'b0;
    end else begin
      st      <= nxt;
      cnt     <= nxt_cnt;
      mode_q  <= nxt_mode;
      ras_n   <= (nxt != SEQ_ACT);
      cas_n   <= !(busy_nxt && !nxt_mode);
      addr_oe <= busy_nxt && nxt_mode;
    end
  end

  assign done = (st == SEQ_PRE) && (cnt == '0);
  assign idle = (st == SEQ_IDLE);

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int CLK_MHZ           = 100,
  parameter int LOW_POWER         = 0,
  parameter int REFRESH_WINDOW_US = (LOW_POWER != 0) ? 64000 : 8000,
  parameter int STARTUP_US        = 200,
  parameter int INIT_CYCLES       = 8,
  parameter int ROW_BITS          = 9,
  parameter int PEND_DEPTH        = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              ras_only_mode,
  input  logic                              rfsh_gnt,
  input  logic                              row_closed,
  output logic                              rfsh_req,
  output logic                              bus_own,
  output logic                              ready,
  output logic                              ras_n,
  output logic                              cas_n,
  output logic                              addr_oe,
  output logic [ROW_BITS-1:0]               row_addr,
  output logic [$clog2(PEND_DEPTH+1)-1:0]   pend_cnt,
  output logic                              overflow
);

  localparam int ROWS        = 1 << ROW_BITS;
  localparam int REFI_CYC    = REFRESH_WINDOW_US * CLK_MHZ / ROWS;
  localparam int STARTUP_CYC = STARTUP_US * CLK_MHZ;
  localparam int T_SETUP_RAW = ns2cyc(10, CLK_MHZ);
  localparam int T_SETUP     = (T_SETUP_RAW < 1) ? 1 : T_SETUP_RAW;
  localparam int T_ACT       = ns2cyc(60, CLK_MHZ);
  localparam int T_RC        = ns2cyc(120, CLK_MHZ);
  localparam int T_RP        = ns2cyc(50, CLK_MHZ);
  localparam int T_PRE       = (T_RP > T_RC - T_SETUP - T_ACT) ? T_RP : T_RC - T_SETUP - T_ACT;
  localparam int IW          = $clog2(INIT_CYCLES + 1);

  ctl_state_e st;
  logic [IW-1:0] init_left;
  logic startup_done, tick;
  logic seq_start, seq_done, seq_idle, can_start, take;

  rfsh_timer #(
    .STARTUP_CYC(STARTUP_CYC),
    .REFI_CYC   (REFI_CYC)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .run_en      (ready),
    .startup_done(startup_done),
    .tick        (tick)
  );

  rfsh_pending #(
    .DEPTH(PEND_DEPTH)
  ) u_pend (
    .clk(clk),
    .rst(rst),
    .inc(tick),
    .dec(take),
    .cnt(pend_cnt),
    .ovf(overflow)
  );

  rfsh_strobe #(
    .T_SETUP(T_SETUP),
    .T_ACT  (T_ACT),
    .T_PRE  (T_PRE)
  ) u_strobe (
    .clk     (clk),
    .rst     (rst),
    .start   (seq_start),
    .ras_only(ras_only_mode),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .addr_oe (addr_oe),
    .done    (seq_done),
    .idle    (seq_idle)
  );

  assign can_start = seq_idle || seq_done;

  always_comb begin
    seq_start = 1'b0;
    take      = 1'b0;
    unique case (st)
      CTL_INIT:  seq_start = can_start && (init_left != '0);
      CTL_READY: begin
        take      = rfsh_gnt && row_closed && (pend_cnt != '0);
        seq_start = take;
      end
      CTL_OWN: begin
        take      = seq_done && (pend_cnt != '0);
        seq_start = take;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= CTL_WAIT;
      init_left <= '0;
    end else begin
      unique case (st)
        CTL_WAIT:
          if (startup_done) begin
            st        <= CTL_INIT;
            init_left <= IW'(INIT_CYCLES);
          end
        CTL_INIT: begin
          if (seq_start) init_left <= init_left - 1'b1;
          if ((init_left == '0) && can_start) st <= CTL_READY;
        end
        CTL_READY: if (take) st <= CTL_OWN;
        CTL_OWN:   if (seq_done && (pend_cnt == '0)) st <= CTL_READY;
        default:   st <= CTL_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           row_addr <= '0;
    else if (seq_done) row_addr <= row_addr + 1'b1;
  end

  assign ready    = (st == CTL_READY) || (st == CTL_OWN);
  assign bus_own  = (st == CTL_OWN);
  assign rfsh_req = (st == CTL_READY) && (pend_cnt != '0);

endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int ROW_BITS   = 9,
  parameter int PEND_DEPTH = 8,
  parameter int T_ACT      = 6
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            ras_n,
  input logic                            cas_n,
  input logic                            addr_oe,
  input logic [ROW_BITS-1:0]             row_addr,
  input logic [$clog2(PEND_DEPTH+1)-1:0] pend_cnt,
  input logic                            overflow,
  input logic                            rfsh_req,
  input logic                            ready,
  input logic                            bus_own,
  input logic                            rfsh_gnt,
  input logic                            row_closed
);

  logic [7:0] low_run;

  always_ff @(posedge clk) begin
    if (rst)        low_run <= '0;
    else if (ras_n) low_run <= '0;
    else            low_run <= low_run + 1'b1;
  end

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));                                    // R3
  AST_ADDR_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
    addr_oe |-> cas_n);                                                             // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && $past(!ras_n)) |-> $stable(row_addr));                               // R4
  AST_RAS_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (low_run == 8'(T_ACT)));                                       // R5
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_addr) |-> (row_addr == ROW_BITS'($past(row_addr) + 1'b1)));        // R6
  AST_REQ_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    rfsh_req |-> ready);                                                            // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    pend_cnt <= PEND_DEPTH);                                                        // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(overflow) |-> overflow);                                                  // R8
  AST_OWN_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_own) |-> $past(rfsh_gnt && row_closed));                              // R9

endmodule

bind rfsh_sched rfsh_sched_chk #(
  .ROW_BITS  (ROW_BITS),
  .PEND_DEPTH(PEND_DEPTH),
  .T_ACT     (T_ACT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .addr_oe   (addr_oe),
  .row_addr  (row_addr),
  .pend_cnt  (pend_cnt),
  .overflow  (overflow),
  .rfsh_req  (rfsh_req),
  .ready     (ready),
  .bus_own   (bus_own),
  .rfsh_gnt  (rfsh_gnt),
  .row_closed(row_closed)
);

// File: tb/rfsh_sched_tb.sv
module rfsh_sched_tb;

  localparam int STARTUP_CYC = 2000;  // 20 us at 100 MHz
  localparam int REFI        = 200;   // 1024 us / 512 rows at 100 MHz
  localparam int T_ACT_EXP   = 6;
  localparam int T_PRE_EXP   = 5;
  localparam int HIGH_MIN    = 6;     // lead phase plus precharge
  localparam int NSTEP       = 5;
  // intervals to wait, expected pend_cnt, expected overflow
  localparam int PTAB [NSTEP][3] = '{
    '{0, 0, 0}, '{1, 1, 0}, '{2, 3, 0}, '{5, 8, 0}, '{1, 8, 1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ras_only_mode = 1'b0, rfsh_gnt = 1'b0, row_closed = 1'b0;
  logic rfsh_req, bus_own, ready, ras_n, cas_n, addr_oe, overflow;
  logic [8:0] row_addr;
  logic [3:0] pend_cnt;

  int checks = 0, fails = 0, cyc = 0;
  int falls = 0, cas_falls = 0, cbr_falls = 0, last_rise = 0;
  int ras_low_run = 0, ras_high_run = 0, cas_low_run = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, cas_broke = 1'b0;

  always #5 clk = ~clk;

  rfsh_sched #(
    .STARTUP_US       (20),
    .REFRESH_WINDOW_US(1024)
  ) u_dut (
    .clk(clk), .rst(rst), .ras_only_mode(ras_only_mode), .rfsh_gnt(rfsh_gnt),
    .row_closed(row_closed), .rfsh_req(rfsh_req), .bus_own(bus_own), .ready(ready),
    .ras_n(ras_n), .cas_n(cas_n), .addr_oe(addr_oe), .row_addr(row_addr),
    .pend_cnt(pend_cnt), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  // strobe monitor: R3 R4 R5 R6 checked on every refresh
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_ras && !ras_n) begin
        chk(ras_high_run >= HIGH_MIN, "R5 RAS high before fall", ras_high_run, HIGH_MIN);
        if (!cas_n) begin
          cbr_falls++;
          chk(cas_low_run == 1, "R3 CAS lead cycles", cas_low_run, 1);
          chk(!addr_oe, "R3 address driven in CBR", addr_oe, 0);
        end else begin
          chk(addr_oe, "R4 addr_oe in RAS-only", addr_oe, 1);
          chk(row_addr == 9'(falls % 512), "R6 RAS-only row", row_addr, falls % 512);
        end
        falls++;
        cas_broke = 1'b0;
      end
      if (!ras_n && (cbr_falls > 0) && !prev_ras && (cas_n != prev_cas)) cas_broke = 1'b1;
      if (!prev_ras && ras_n) begin
        chk(ras_low_run == T_ACT_EXP, "R5 RAS low width", ras_low_run, T_ACT_EXP);
        chk(!cas_broke, "R3/R4 CAS changed under RAS", cas_broke, 0);
        last_rise = cyc;
      end
      if (prev_cas && !cas_n) cas_falls++;
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      cas_low_run  = cas_n ? 0 : cas_low_run + 1;
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int f0, c0, t0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(ras_n && cas_n && !addr_oe, "R11 strobes in reset", {ras_n, cas_n, addr_oe}, 3'b110);
    chk(!ready && !rfsh_req && !bus_own, "R11 handshake in reset", {ready, rfsh_req, bus_own}, 0);
    chk(pend_cnt == 0 && !overflow, "R11 pending in reset", {overflow, pend_cnt}, 0);
    rst = 1'b0;

    // R1 quiet during the start-up wait
    repeat (STARTUP_CYC - 10) @(negedge clk);
    chk(falls == 0 && cas_falls == 0, "R1 strobe moved during wait", falls + cas_falls, 0);
    chk(!ready, "R1 ready during wait", ready, 0);

    // R2 initialization cycles (CBR since ras_only_mode=0)
    while (!ready) @(negedge clk);
    chk(falls == 8, "R2 init refresh count", falls, 8);
    chk(cbr_falls == 8, "R3 init cycles were CBR", cbr_falls, 8);
    chk(cyc - last_rise == T_PRE_EXP, "R2 ready after precharge", cyc - last_rise, T_PRE_EXP);
    chk(cyc > STARTUP_CYC, "R1 ready not before wait", cyc, STARTUP_CYC);

    // R7 R8 accumulation table, no grant given
    repeat (REFI / 2) @(negedge clk);
    for (int i = 0; i < NSTEP; i++) begin
      repeat (PTAB[i][0] * REFI) @(negedge clk);
      chk(pend_cnt == 4'(PTAB[i][1]), "R7/R8 pend_cnt", pend_cnt, PTAB[i][1]);
      chk(overflow == PTAB[i][2][0], "R8 overflow", overflow, PTAB[i][2]);
      chk(rfsh_req == (PTAB[i][1] != 0), "R7 rfsh_req", rfsh_req, PTAB[i][1] != 0);
    end

    // R9 grant with a row open is ignored
    ras_only_mode = 1'b1;
    f0 = falls; c0 = cas_falls;
    rfsh_gnt = 1'b1;
    repeat (20) @(negedge clk);
    chk(falls == f0 && cas_falls == c0, "R9 strobe moved with row open", falls - f0, 0);
    chk(!bus_own, "R9 bus_own with row open", bus_own, 0);
    chk(pend_cnt == 8, "R9 pending kept", pend_cnt, 8);

    // R10 burst drain in RAS-only mode, just after an interval tick
    repeat (90) @(negedge clk);
    f0 = falls; c0 = cas_falls;
    row_closed = 1'b1;
    while (!bus_own) @(negedge clk);
    while (bus_own) @(negedge clk);
    chk(falls - f0 == 8, "R10 burst length", falls - f0, 8);
    chk(cas_falls == c0, "R4 CAS fell in RAS-only", cas_falls - c0, 0);
    chk(pend_cnt == 0, "R10 pending drained", pend_cnt, 0);
    chk(cyc - last_rise == T_PRE_EXP, "R10 release after precharge", cyc - last_rise, T_PRE_EXP);
    chk(overflow, "R8 overflow sticky", overflow, 1);

    // R6 wrap: keep granting, one refresh per interval
    repeat (510 * REFI) @(negedge clk);
    chk(falls > 512, "R6 enough refreshes to wrap", falls, 513);
    t0 = falls;
    while (ras_n == 1'b0 || bus_own) @(negedge clk);
    chk(row_addr == 9'(falls % 512), "R6 row after wrap", row_addr, falls % 512);
    chk(pend_cnt <= 1, "R10 pending kept drained", pend_cnt, 1);

    // R3 back to CBR after RAS-only
    ras_only_mode = 1'b0;
    c0 = cbr_falls;
    repeat (3 * REFI) @(negedge clk);
    chk(cbr_falls - c0 >= 2, "R3 CBR refreshes run", cbr_falls - c0, 2);
    chk(falls >= t0 + 2, "R7 rate kept", falls - t0, 2);
    finish_run();
  end

endmodule